// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the state kept for each interrupt in an interrupt controller. For every interrupt it stores an enable bit, a pending bit, the last sampled input level, a model bit, a trigger-type bit, an 8-bit priority and an 8-bit CPU target. Software reaches this state through a byte-addressed register port. Enables and pending bits sit in paired set and clear banks, so one write changes only the bits written as 1. Software can also make an interrupt pending by writing its ID to a trigger register.

The block samples the external interrupt lines once per clock. It turns a change on a line into level and pending updates for the matching interrupt. It drives the enable, pending, level, trigger and priority vectors to a separate arbiter. The CPU interface drives strobes back into the block. These strobes set or clear single pending bits, for example when an interrupt is acknowledged or completed. The CPU interface also supplies the active vector, which software can read but not write.

Top module: `intc_dist_regs`

## Requirements
- R1: After reset, IDs 0 to 14 are enabled and edge-triggered. All other enable, pending, level, model and trigger bits are 0, every priority and target byte is 0, and the global enable is 0.
- R2: At offset 0x000, bit 0 is the global enable, and software can read and write it. Offset 0x004 reads as NUM_IRQ/32-1. The other offsets from 0x001 to 0x007 read as 0.
- R3: In the enable bank, a byte at 0x100+g sets enables and a byte at 0x180+g clears them. Data bit b acts on ID 8g+b, and a 0 bit changes nothing. A read from either range returns the current enable bits.
- R4: The pending bank works the same way, with set at 0x200+g and clear at 0x280+g. The active bits read at 0x300+g, and writes to that range change nothing.
- R5: Priority is one byte at 0x400+ID and CPU target is one byte at 0x800+ID. Both can be read and written. The priority of ID n appears on irq_prio[8n+7:8n].
- R6: The configuration byte at 0xC00+k covers IDs 4k to 4k+3. Bit 2j is the model bit of ID 4k+j and bit 2j+1 is its edge-trigger bit.
- R7: A write to 0xF00 sets the pending bit of the ID held in wdata[9:0].
- R8: The word-aligned offsets 0xFE0 to 0xFFC read the identification bytes 0x90, 0x13, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order. The other offsets in that range read as 0.
- R9: Input line n drives ID n+32. A rising line sets the level bit, and also sets the pending bit if the ID is edge-triggered or enabled. A falling line clears only the level bit.
- R10: Setting the enable of a level-triggered ID whose level bit is 1 also sets its pending bit.
- R11: For IDs at or above NUM_IRQ, and at undefined offsets, reads return 0 and writes change nothing.
- R12: The CPU pending-set and pending-clear strobes take priority over input capture and register writes in the same cycle. When both strobes name the same ID, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 12 | Byte offset from the bank base |
| wdata | input | 16 | Write data. Bits 7:0 are the byte; bits 9:0 are the ID for the trigger register |
| rdata | output | 8 | Read data for addr |
| irq_in | input | NUM_IRQ-32 | External interrupt lines |
| irq_active | input | NUM_IRQ | Active bits from the CPU interface |
| cpu_set_pend | input | 1 | Strobe that sets one pending bit |
| cpu_set_id | input | 10 | ID for cpu_set_pend |
| cpu_clr_pend | input | 1 | Strobe that clears one pending bit |
| cpu_clr_id | input | 10 | ID for cpu_clr_pend |
| dist_on | output | 1 | Global enable |
| irq_enable | output | NUM_IRQ | Enable bits |
| irq_pending | output | NUM_IRQ | Pending bits |
| irq_level | output | NUM_IRQ | Sampled input levels |
| irq_trig_edge | output | NUM_IRQ | Edge-trigger configuration bits |
| irq_prio | output | 8*NUM_IRQ | Priority bytes, ID n at bits 8n+7:8n |

## Verification
With the default RD_PIPE of 0, rdata follows addr in the same cycle, so the bench checks a read 1 ns after it drives the address. Writes, strobes and input changes take effect at the next rising edge. The bench therefore drives these inputs on a falling edge and checks the state one falling edge later, exactly one register stage on. Level capture also has a single register stage: a line change shows up in the level and pending outputs at the first rising edge after the change. The bench checks those outputs one cycle after each change.

// File: rtl/intc_dist_pkg.sv
package intc_dist_pkg;

   typedef enum logic [3:0] {
      RG_CTRL, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD, RG_ACT,
      RG_PRIO, RG_TGT, RG_CFG, RG_SGI, RG_IDB, RG_NONE
   } region_e;

   typedef struct packed {
      logic set_en;
      logic clr_en;
      logic set_pnd;
      logic clr_pnd;
      logic wr_prio;
      logic wr_tgt;
      logic wr_cfg;
   } cell_cmd_t;

   function automatic region_e decode_region(input logic [11:0] a);
      region_e r;
      unique case (a[11:8])
         4'h0: r = (a[7:3] == 5'd0) ? RG_CTRL : RG_NONE;
         4'h1: r = a[7] ? RG_CLREN : RG_SETEN;
         4'h2: r = a[7] ? RG_CLRPD : RG_SETPD;
         4'h3: r = RG_ACT;
         4'h4, 4'h5, 4'h6, 4'h7: r = RG_PRIO;
         4'h8, 4'h9, 4'hA, 4'hB: r = RG_TGT;
         4'hC, 4'hD, 4'hE: r = RG_CFG;
         default: begin
            if (a == 12'hF00)          r = RG_SGI;
            else if (a[7:5] == 3'b111) r = RG_IDB;
            else                       r = RG_NONE;
         end
      endcase
      return r;
   endfunction

   function automatic logic [7:0] ident_byte(input logic [2:0] k);
      logic [7:0] b;
      unique case (k)
         3'd0: b = 8'h90;
         3'd1: b = 8'h13;
         3'd2: b = 8'h04;
         3'd3: b = 8'h00;
         3'd4: b = 8'h0D;
         3'd5: b = 8'hF0;
         3'd6: b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/intc_irq_cell.sv
module intc_irq_cell
   import intc_dist_pkg::*;
#(
   parameter bit RST_ON = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cell_cmd_t  cmd,
   input  logic [7:0] wbyte,
   input  logic [1:0] cfg_bits,
   input  logic       line_in,
   input  logic       sw_set,
   input  logic       cpu_set,
   input  logic       cpu_clr,
   output logic       en_q,
   output logic       pnd_q,
   output logic       lvl_q,
   output logic       model_q,
   output logic       trig_q,
   output logic [7:0] prio_q,
   output logic [7:0] tgt_q
);

   logic rise, fall, pnd_d;

   assign rise = line_in & ~lvl_q;
   assign fall = ~line_in & lvl_q;

   always_comb begin
      pnd_d = pnd_q;
      if (rise && (trig_q || en_q))            pnd_d = 1'b1;
      if (cmd.set_en && lvl_q && !trig_q)      pnd_d = 1'b1;
      if (cmd.set_pnd || sw_set)               pnd_d = 1'b1;
      if (cmd.clr_pnd)                         pnd_d = 1'b0;
      if (cpu_set)                             pnd_d = 1'b1;
      if (cpu_clr)                             pnd_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= RST_ON;
         trig_q  <= RST_ON;
         pnd_q   <= 1'b0;
         lvl_q   <= 1'b0;
         model_q <= 1'b0;
         prio_q  <= '0;
         tgt_q   <= '0;
      end else begin
         lvl_q <= line_in;
         pnd_q <= pnd_d;
         if (cmd.set_en)       en_q <= 1'b1;
         else if (cmd.clr_en)  en_q <= 1'b0;
         if (cmd.wr_prio) prio_q <= wbyte;
         if (cmd.wr_tgt)  tgt_q  <= wbyte;
         if (cmd.wr_cfg) begin
            model_q <= cfg_bits[0];
            trig_q  <= cfg_bits[1];
         end
      end
   end

   a_r12_cpu_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clr |=> !pnd_q);
   a_r12_cpu_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_set && !cpu_clr) |=> pnd_q);
   a_r9_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && (trig_q || en_q) && !cpu_clr && !cmd.clr_pnd) |=> pnd_q);
   a_r9_fall_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && cmd == '0 && !sw_set && !cpu_set && !cpu_clr) |=> (pnd_q == $past(pnd_q)));
   a_r9_fall_clears_level: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !lvl_q);
   a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.set_en |=> en_q);

endmodule

// File: rtl/intc_dist_rdmux.sv
module intc_dist_rdmux
   import intc_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic [11:0]          addr,
   input  logic                 dist_on,
   input  logic [NUM_IRQ-1:0]   en_v,
   input  logic [NUM_IRQ-1:0]   pnd_v,
   input  logic [NUM_IRQ-1:0]   act_v,
   input  logic [NUM_IRQ-1:0]   model_v,
   input  logic [NUM_IRQ-1:0]   trig_v,
   input  logic [8*NUM_IRQ-1:0] prio_v,
   input  logic [8*NUM_IRQ-1:0] tgt_v,
   output logic [7:0]           rd_byte
);

   localparam logic [7:0] LINES_CODE = 8'(NUM_IRQ / 32 - 1);

   function automatic logic [7:0] bank_byte(input logic [NUM_IRQ-1:0] v, input int g);
      logic [7:0] r;
      r = '0;
      for (int b = 0; b < 8; b++) begin
         if (g * 8 + b < NUM_IRQ) r[b] = v[g * 8 + b];
      end
      return r;
   endfunction

   region_e rgn;
   int      idx;

   always_comb begin
      rgn     = decode_region(addr);
      idx     = int'(addr[9:0]);
      rd_byte = '0;
      unique case (rgn)
         RG_CTRL: begin
            if (addr[2:0] == 3'd0)      rd_byte = {7'd0, dist_on};
            else if (addr[2:0] == 3'd4) rd_byte = LINES_CODE;
         end
         RG_SETEN, RG_CLREN: rd_byte = bank_byte(en_v, int'(addr[6:0]));
         RG_SETPD, RG_CLRPD: rd_byte = bank_byte(pnd_v, int'(addr[6:0]));
         RG_ACT:             rd_byte = bank_byte(act_v, int'(addr[7:0]));
         RG_PRIO: if (idx < NUM_IRQ) rd_byte = prio_v[idx*8 +: 8];
         RG_TGT:  if (idx < NUM_IRQ) rd_byte = tgt_v[idx*8 +: 8];
         RG_CFG: begin
            for (int j = 0; j < 4; j++) begin
               if (idx * 4 + j < NUM_IRQ) begin
                  rd_byte[2*j]   = model_v[idx*4 + j];
                  rd_byte[2*j+1] = trig_v[idx*4 + j];
               end
            end
         end
         RG_IDB: if (addr[1:0] == 2'b00) rd_byte = ident_byte(addr[4:2]);
         default: rd_byte = '0;
      endcase
   end

endmodule

// File: rtl/intc_dist_regs.sv
module intc_dist_regs
   import intc_dist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter bit RD_PIPE = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [11:0]            addr,
   input  logic [15:0]            wdata,
   output logic [7:0]             rdata,
   input  logic [NUM_IRQ-33:0]    irq_in,
   input  logic [NUM_IRQ-1:0]     irq_active,
   input  logic                   cpu_set_pend,
   input  logic [9:0]             cpu_set_id,
   input  logic                   cpu_clr_pend,
   input  logic [9:0]             cpu_clr_id,
   output logic                   dist_on,
   output logic [NUM_IRQ-1:0]     irq_enable,
   output logic [NUM_IRQ-1:0]     irq_pending,
   output logic [NUM_IRQ-1:0]     irq_level,
   output logic [NUM_IRQ-1:0]     irq_trig_edge,
   output logic [8*NUM_IRQ-1:0]   irq_prio
);

   localparam int NUM_EXT    = NUM_IRQ - 32;
   localparam int NUM_RST_ON = 15;

   if (NUM_IRQ < 64 || NUM_IRQ > 1020 || (NUM_IRQ % 32) != 0) begin : g_bad_count
      $error("intc_dist_regs: NUM_IRQ must be a multiple of 32 between 64 and 1020");
   end

   region_e                  rgn;
   logic [NUM_IRQ-1:0]       model_v;
   logic [8*NUM_IRQ-1:0]     tgt_v;
   logic [7:0]               rd_byte;

   assign rgn = decode_region(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                dist_on <= 1'b0;
      else if (wr_en && addr == 12'h000)         dist_on <= wdata[0];
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
      localparam int GRP = i / 8;
      localparam int BIT = i % 8;
      localparam int CK  = i / 4;
      localparam int CJ  = i % 4;

      cell_cmd_t cmd;
      logic      line;
      logic      sw_set, cpu_set, cpu_clr;

      assign cmd.set_en  = wr_en && rgn == RG_SETEN && addr[6:0] == 7'(GRP) && wdata[BIT];
      assign cmd.clr_en  = wr_en && rgn == RG_CLREN && addr[6:0] == 7'(GRP) && wdata[BIT];
      assign cmd.set_pnd = wr_en && rgn == RG_SETPD && addr[6:0] == 7'(GRP) && wdata[BIT];
      assign cmd.clr_pnd = wr_en && rgn == RG_CLRPD && addr[6:0] == 7'(GRP) && wdata[BIT];
      assign cmd.wr_prio = wr_en && rgn == RG_PRIO && addr[9:0] == 10'(i);
      assign cmd.wr_tgt  = wr_en && rgn == RG_TGT  && addr[9:0] == 10'(i);
      assign cmd.wr_cfg  = wr_en && rgn == RG_CFG  && addr[9:0] == 10'(CK);
      assign sw_set      = wr_en && rgn == RG_SGI  && wdata[9:0] == 10'(i);
      assign cpu_set     = cpu_set_pend && cpu_set_id == 10'(i);
      assign cpu_clr     = cpu_clr_pend && cpu_clr_id == 10'(i);

      if (i >= 32) begin : g_ext
         assign line = irq_in[i - 32];
      end else begin : g_int
         assign line = 1'b0;
      end

      intc_irq_cell #(.RST_ON(i < NUM_RST_ON)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd      (cmd),
         .wbyte    (wdata[7:0]),
         .cfg_bits (wdata[2*CJ +: 2]),
         .line_in  (line),
         .sw_set   (sw_set),
         .cpu_set  (cpu_set),
         .cpu_clr  (cpu_clr),
         .en_q     (irq_enable[i]),
         .pnd_q    (irq_pending[i]),
         .lvl_q    (irq_level[i]),
         .model_q  (model_v[i]),
         .trig_q   (irq_trig_edge[i]),
         .prio_q   (irq_prio[8*i +: 8]),
         .tgt_q    (tgt_v[8*i +: 8])
      );
   end

   intc_dist_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rdmux (
      .addr    (addr),
      .dist_on (dist_on),
      .en_v    (irq_enable),
      .pnd_v   (irq_pending),
      .act_v   (irq_active),
      .model_v (model_v),
      .trig_v  (irq_trig_edge),
      .prio_v  (irq_prio),
      .tgt_v   (tgt_v),
      .rd_byte (rd_byte)
   );

   if (RD_PIPE) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_byte;
      end
   end else begin : g_rd_comb
      assign rdata = rd_byte;
   end

   a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 12'h000) |=> (dist_on == $past(wdata[0])));
   a_r7_sgi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 12'hF00 && int'(wdata[9:0]) < NUM_IRQ && !cpu_clr_pend)
      |=> irq_pending[$past(wdata[9:0])]);
   a_r11_oor_sgi_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 12'hF00 && int'(wdata[9:0]) >= NUM_IRQ && !cpu_set_pend)
      |=> ($countones(irq_pending) <= $countones($past(irq_pending))));
   a_r4_active_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rgn == RG_ACT && !cpu_set_pend && !cpu_clr_pend && irq_in == irq_level[NUM_IRQ-1:32])
      |=> $stable(irq_pending) && $stable(irq_enable));

endmodule

// File: tb/intc_dist_regs_bench.sv
module intc_dist_regs_bench;

   localparam int CLK_NS = 10;
   localparam int N      = 64;

   typedef struct packed {
      logic        is_wr;
      logic [11:0] a;
      logic [15:0] d;
      logic [7:0]  exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VT [NV] = '{
      '{1'b0, 12'h000, 16'h0000, 8'h00, 4'd2},  // R2 global enable off
      '{1'b0, 12'h004, 16'h0000, 8'h01, 4'd2},  // R2 line count code
      '{1'b0, 12'h006, 16'h0000, 8'h00, 4'd2},  // R2 reserved
      '{1'b0, 12'h100, 16'h0000, 8'hFF, 4'd1},  // R1 IDs 0-7 on
      '{1'b0, 12'h101, 16'h0000, 8'h7F, 4'd1},  // R1 IDs 8-14 on
      '{1'b0, 12'h102, 16'h0000, 8'h00, 4'd1},  // R1
      '{1'b0, 12'h181, 16'h0000, 8'h7F, 4'd3},  // R3 clear bank reads enables
      '{1'b0, 12'hC00, 16'h0000, 8'hAA, 4'd1},  // R1 edge bits
      '{1'b0, 12'hC03, 16'h0000, 8'h2A, 4'd1},  // R1 IDs 12-14 edge
      '{1'b1, 12'h000, 16'h0001, 8'h00, 4'd2},
      '{1'b0, 12'h000, 16'h0000, 8'h01, 4'd2},  // R2
      '{1'b1, 12'h104, 16'h0005, 8'h00, 4'd3},
      '{1'b0, 12'h184, 16'h0000, 8'h05, 4'd3},  // R3 set
      '{1'b1, 12'h184, 16'h0001, 8'h00, 4'd3},
      '{1'b0, 12'h104, 16'h0000, 8'h04, 4'd3},  // R3 clear
      '{1'b1, 12'h184, 16'h0000, 8'h00, 4'd3},
      '{1'b0, 12'h104, 16'h0000, 8'h04, 4'd3},  // R3 zero bits inert
      '{1'b1, 12'h205, 16'h0081, 8'h00, 4'd4},
      '{1'b0, 12'h285, 16'h0000, 8'h81, 4'd4},  // R4 set pending
      '{1'b1, 12'h285, 16'h0001, 8'h00, 4'd4},
      '{1'b0, 12'h205, 16'h0000, 8'h80, 4'd4},  // R4 clear pending
      '{1'b1, 12'h300, 16'h00FF, 8'h00, 4'd4},
      '{1'b0, 12'h300, 16'h0000, 8'h00, 4'd4},  // R4 active read-only
      '{1'b1, 12'h42A, 16'h005C, 8'h00, 4'd5},
      '{1'b0, 12'h42A, 16'h0000, 8'h5C, 4'd5},  // R5 priority
      '{1'b1, 12'h83F, 16'h0003, 8'h00, 4'd5},
      '{1'b0, 12'h83F, 16'h0000, 8'h03, 4'd5},  // R5 target
      '{1'b1, 12'hC0A, 16'h00E4, 8'h00, 4'd6},
      '{1'b0, 12'hC0A, 16'h0000, 8'hE4, 4'd6},  // R6 config packing
      '{1'b1, 12'hF00, 16'h0033, 8'h00, 4'd7},
      '{1'b0, 12'h206, 16'h0000, 8'h08, 4'd7},  // R7 ID 51 pending
      '{1'b1, 12'hF00, 16'h0040, 8'h00, 4'd11},
      '{1'b0, 12'h206, 16'h0000, 8'h08, 4'd11}, // R11 out-of-range trigger
      '{1'b0, 12'h208, 16'h0000, 8'h00, 4'd11}, // R11
      '{1'b0, 12'hFE0, 16'h0000, 8'h90, 4'd8},  // R8
      '{1'b0, 12'hFE4, 16'h0000, 8'h13, 4'd8},  // R8
      '{1'b0, 12'hFFC, 16'h0000, 8'hB1, 4'd8},  // R8
      '{1'b0, 12'hFE1, 16'h0000, 8'h00, 4'd8},  // R8 unaligned
      '{1'b1, 12'h108, 16'h00FF, 8'h00, 4'd11},
      '{1'b0, 12'h108, 16'h0000, 8'h00, 4'd11}, // R11 enable beyond count
      '{1'b1, 12'h440, 16'h0011, 8'h00, 4'd11},
      '{1'b0, 12'h440, 16'h0000, 8'h00, 4'd11}, // R11 priority beyond count
      '{1'b0, 12'h050, 16'h0000, 8'h00, 4'd11}, // R11 hole
      '{1'b0, 12'hF04, 16'h0000, 8'h00, 4'd11}  // R11 hole
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [11:0]     addr = '0;
   logic [15:0]     wdata = '0;
   logic [7:0]      rdata;
   logic [N-33:0]   irq_in = '0;
   logic [N-1:0]    irq_active = '0;
   logic            cpu_set_pend = 1'b0;
   logic [9:0]      cpu_set_id = '0;
   logic            cpu_clr_pend = 1'b0;
   logic [9:0]      cpu_clr_id = '0;
   logic            dist_on;
   logic [N-1:0]    irq_enable, irq_pending, irq_level, irq_trig_edge;
   logic [8*N-1:0]  irq_prio;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   intc_dist_regs #(.NUM_IRQ(N)) u_intc_dist_regs (
      .clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .irq_in, .irq_active,
      .cpu_set_pend, .cpu_set_id, .cpu_clr_pend, .cpu_clr_id,
      .dist_on, .irq_enable, .irq_pending, .irq_level, .irq_trig_edge, .irq_prio
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq_in = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R1 reset state at the ports
      chk(64'(irq_enable),    64'h7FFF, "R1 enable vector");
      chk(64'(irq_trig_edge), 64'h7FFF, "R1 edge vector");
      chk(64'(irq_pending),   64'h0,    "R1 pending vector");
      chk(64'(dist_on),       64'h0,    "R1 global enable");

      for (int v = 0; v < NV; v++) begin
         if (VT[v].is_wr) begin
            do_wr(VT[v].a, VT[v].d);
         end else begin
            @(negedge clk);
            addr = VT[v].a;
            #1;
            chk(64'(rdata), 64'(VT[v].exp), $sformatf("R%0d read %03h", VT[v].req, VT[v].a));
         end
      end

      chk(64'(irq_prio[42*8 +: 8]), 64'h5C, "R5 priority output ID42");
      chk(64'(irq_trig_edge[42]),   64'h1,  "R6 edge output ID42");

      do_reset();
      // R9 disabled level input: level only
      @(negedge clk); irq_in[5] = 1'b1;
      @(negedge clk);
      chk(64'(irq_level[37]),   64'h1, "R9 level ID37");
      chk(64'(irq_pending[37]), 64'h0, "R9 no pend disabled level");
      // R10 enabling a raised level input pends it
      do_wr(12'h104, 16'h0020);
      chk(64'(irq_pending[37]), 64'h1, "R10 enable raised level");
      // R9 falling line clears level only
      irq_in[5] = 1'b0;
      @(negedge clk);
      chk(64'(irq_level[37]),   64'h0, "R9 level falls ID37");
      chk(64'(irq_pending[37]), 64'h1, "R9 pending kept ID37");
      // R9 edge-configured input pends while disabled
      do_wr(12'hC09, 16'h0020);
      irq_in[6] = 1'b1;
      @(negedge clk);
      chk(64'(irq_pending[38]), 64'h1, "R9 edge pends ID38");
      chk(64'(irq_enable[38]),  64'h0, "R9 ID38 stays disabled");
      // R9 enabled level input pends on rise
      do_wr(12'h104, 16'h0080);
      irq_in[7] = 1'b1;
      @(negedge clk);
      chk(64'(irq_pending[39]), 64'h1, "R9 enabled level pends ID39");
      // R12 CPU clear beats capture in the same cycle
      do_wr(12'h104, 16'h0002);
      irq_in[1] = 1'b1; cpu_clr_pend = 1'b1; cpu_clr_id = 10'd33;
      @(negedge clk);
      cpu_clr_pend = 1'b0;
      chk(64'(irq_pending[33]), 64'h0, "R12 clear beats capture");
      chk(64'(irq_level[33]),   64'h1, "R12 level still captured");
      // R12 CPU set beats register clear
      wr_en = 1'b1; addr = 12'h284; wdata = 16'h0010;
      cpu_set_pend = 1'b1; cpu_set_id = 10'd36;
      @(negedge clk);
      wr_en = 1'b0; cpu_set_pend = 1'b0;
      chk(64'(irq_pending[36]), 64'h1, "R12 set beats register clear");
      // R12 clear beats set for same ID
      cpu_set_pend = 1'b1; cpu_set_id = 10'd36;
      cpu_clr_pend = 1'b1; cpu_clr_id = 10'd36;
      @(negedge clk);
      cpu_set_pend = 1'b0; cpu_clr_pend = 1'b0;
      chk(64'(irq_pending[36]), 64'h0, "R12 clear beats set");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule